// File: doc/BRIEF.md
# Aliased Floating-Point Register File with Host Transfer Port

This block holds the register storage of a floating-point coprocessor and the port through which a general-purpose host core moves 32-bit words into and out of it. One array of thirty-two 32-bit words can be addressed two ways. As single registers it is S0 to S31. As double registers it is D0 to D15, where Dn takes S(2n) as its low half and S(2n+1) as its high half. Five system registers sit beside the array: a read-only identification word, status/control, exception, instruction and second instruction.

Operations arrive already decoded. A write is a valid strobe with a 3-bit opcode, a 5-bit index and up to two 32-bit data words. It takes effect at the next rising clock edge. One opcode writes a single register. Two opcodes write one half of a double and leave the other half alone. Two opcodes write two words at once, either into both halves of a double or into a pair of consecutive singles. One opcode writes a system register. A separate read select returns a 32-bit word combinationally from the current contents. The block has no error or exception output, because no transfer can fail.

Top module: `fpreg_xfer_port`

## Requirements
- R1: With `xfer_valid`=1 and `xfer_op`=0, `xfer_wdata0` is stored into single register S[`xfer_idx`]. A read with `rd_kind`=0 returns S[`rd_idx`].
- R2: With `xfer_op`=1, `xfer_wdata0` is stored into the low half of double D[`xfer_idx[3:0]`], which is S(2n). The high half S(2n+1) is unchanged. Bit 4 of the index is ignored for every double access.
- R3: With `xfer_op`=2, `xfer_wdata0` is stored into the high half of D[`xfer_idx[3:0]`], which is S(2n+1). The low half S(2n) is unchanged.
- R4: A read with `rd_kind`=1 returns the low half of D[`rd_idx[3:0]`]. A read with `rd_kind`=2 returns its high half.
- R5: With `xfer_op`=3, both halves of D[`xfer_idx[3:0]`] are written in one edge: `xfer_wdata0` to the low half and `xfer_wdata1` to the high half.
- R6: With `xfer_op`=4, one edge writes `xfer_wdata0` into S[m] and `xfer_wdata1` into S[m+1], where m is `xfer_idx`. For m=31 the second word wraps around to S0.
- R7: The system registers are selected by index bits [2:0]: 0 identification, 1 status/control, 2 exception, 3 instruction, 4 second instruction. `xfer_op`=5 writes `xfer_wdata0` to the selected register and `rd_kind`=3 reads it. For selects 5 to 7, writes are ignored and reads return zero.
- R8: A write to the identification register leaves it unchanged. It always reads as the `ID_VALUE` parameter.
- R9: While `rst_n` is low, all singles and the four writable system registers are cleared to zero.
- R10: When `xfer_valid` is 0, or when `xfer_op` is 6 or 7, no register changes.
- R11: Read data follows the current contents combinationally. A write becomes visible on the read port only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Write operation strobe |
| xfer_op | input | 3 | Decoded write opcode (0 to 5 used, 6 and 7 no effect) |
| xfer_idx | input | 5 | Register index for the write |
| xfer_wdata0 | input | 32 | First host word |
| xfer_wdata1 | input | 32 | Second host word (two-word writes only) |
| rd_kind | input | 2 | Read view: 0 single, 1 double low, 2 double high, 3 system |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 32 | Combinational read data |

## Verification
The assertions assume that at most one write opcode arrives per cycle. They also assume that the opcode, index and data are stable and known around each rising edge while `xfer_valid` is high. The post-write properties then compare an array word with the data sampled one edge earlier. The bench drives every input on the falling edge and drops `xfer_valid` after each write. The bench samples the read port a moment after that falling edge, so every vector covers exactly one write and one read.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned FPX_WORD_W = 32;

    typedef enum logic [2:0] {
        OP_SGL_WR   = 3'd0,
        OP_DLO_WR   = 3'd1,
        OP_DHI_WR   = 3'd2,
        OP_DBL_PAIR = 3'd3,
        OP_SGL_PAIR = 3'd4,
        OP_SYS_WR   = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } xfer_op_e;

    typedef enum logic [1:0] {
        RD_SGL = 2'd0,
        RD_DLO = 2'd1,
        RD_DHI = 2'd2,
        RD_SYS = 2'd3
    } rd_kind_e;

    localparam logic [2:0] SYS_ID    = 3'd0;
    localparam logic [2:0] SYS_CTRL  = 3'd1;
    localparam logic [2:0] SYS_EXC   = 3'd2;
    localparam logic [2:0] SYS_INST  = 3'd3;
    localparam logic [2:0] SYS_INST2 = 3'd4;

    typedef struct packed {
        logic [FPX_WORD_W-1:0] ctrl;
        logic [FPX_WORD_W-1:0] exc;
        logic [FPX_WORD_W-1:0] inst;
        logic [FPX_WORD_W-1:0] inst2;
    } sys_state_t;

endpackage

// File: rtl/fpx_wr_decode.sv
// Per-word write enables and data-lane selection for the aliased array.
module fpx_wr_decode #(
    parameter int unsigned NUM_SGL = 32,
    parameter int unsigned IDX_W   = $clog2(NUM_SGL)
) (
    input  logic             xfer_valid,
    input  logic [2:0]       xfer_op,
    input  logic [IDX_W-1:0] xfer_idx,
    output logic [NUM_SGL-1:0] wr_en,
    output logic [NUM_SGL-1:0] lane_hi
);
    import fpx_pkg::*;

    localparam int unsigned DIDX_W = IDX_W - 1;

    logic [DIDX_W-1:0] dbl_idx;
    logic [IDX_W-1:0]  pair_nxt;

    assign dbl_idx  = xfer_idx[DIDX_W-1:0];
    assign pair_nxt = xfer_idx + 1'b1;   // wraps at the top of the array

    for (genvar g = 0; g < NUM_SGL; g++) begin : g_word
        localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(g);
        localparam logic [DIDX_W-1:0] MY_DBL  = DIDX_W'(g / 2);
        localparam bit                MY_ODD  = (g % 2) == 1;

        logic dbl_hit;
        assign dbl_hit = (dbl_idx == MY_DBL);

        always_comb begin
            wr_en[g]   = 1'b0;
            lane_hi[g] = 1'b0;
            if (xfer_valid) begin
                case (xfer_op)
                    OP_SGL_WR: begin
                        wr_en[g] = (xfer_idx == MY_IDX);
                    end
                    OP_DLO_WR: begin
                        wr_en[g] = dbl_hit && !MY_ODD;
                    end
                    OP_DHI_WR: begin
                        wr_en[g] = dbl_hit && MY_ODD;
                    end
                    OP_DBL_PAIR: begin
                        wr_en[g]   = dbl_hit;
                        lane_hi[g] = MY_ODD;
                    end
                    OP_SGL_PAIR: begin
                        if (xfer_idx == MY_IDX) begin
                            wr_en[g] = 1'b1;
                        end else if (pair_nxt == MY_IDX) begin
                            wr_en[g]   = 1'b1;
                            lane_hi[g] = 1'b1;
                        end
                    end
                    default: begin
                        wr_en[g] = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fpx_sgl_bank.sv
// Thirty-two word storage shared by the single and double views.
module fpx_sgl_bank #(
    parameter int unsigned NUM_SGL = 32,
    parameter int unsigned WORD_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SGL-1:0]              wr_en,
    input  logic [NUM_SGL-1:0]              lane_hi,
    input  logic [WORD_W-1:0]               wdata0,
    input  logic [WORD_W-1:0]               wdata1,
    output logic [NUM_SGL-1:0][WORD_W-1:0]  words
);
    logic [NUM_SGL-1:0][WORD_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_SGL; i++) begin
            if (wr_en[i]) begin
                regs_d[i] = lane_hi[i] ? wdata1 : wdata0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign words = regs_q;

endmodule

// File: rtl/fpx_sys_bank.sv
// System register bank; the identification word is a constant.
module fpx_sys_bank #(
    parameter int unsigned        WORD_W   = 32,
    parameter logic [WORD_W-1:0]  ID_VALUE = 32'h5A01_0C33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [2:0]        rd_sel,
    output logic [WORD_W-1:0] rdata
);
    import fpx_pkg::*;

    sys_state_t sys_d, sys_q;

    always_comb begin
        sys_d = sys_q;
        if (wr_stb) begin
            case (wr_sel)
                SYS_CTRL:  sys_d.ctrl  = wdata;
                SYS_EXC:   sys_d.exc   = wdata;
                SYS_INST:  sys_d.inst  = wdata;
                SYS_INST2: sys_d.inst2 = wdata;
                default:   sys_d = sys_q;  // identification and unmapped: dropped
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_q <= '0;
        end else begin
            sys_q <= sys_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SYS_ID:    rdata = ID_VALUE;
            SYS_CTRL:  rdata = sys_q.ctrl;
            SYS_EXC:   rdata = sys_q.exc;
            SYS_INST:  rdata = sys_q.inst;
            SYS_INST2: rdata = sys_q.inst2;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/fpx_rd_mux.sv
// Combinational read selection across the three views.
module fpx_rd_mux #(
    parameter int unsigned NUM_SGL = 32,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned IDX_W   = $clog2(NUM_SGL)
) (
    input  logic [1:0]                      rd_kind,
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [NUM_SGL-1:0][WORD_W-1:0]  words,
    input  logic [WORD_W-1:0]               sys_rdata,
    output logic [WORD_W-1:0]               rd_data
);
    import fpx_pkg::*;

    logic [IDX_W-1:0] lo_idx, hi_idx;

    assign lo_idx = {rd_idx[IDX_W-2:0], 1'b0};
    assign hi_idx = {rd_idx[IDX_W-2:0], 1'b1};

    always_comb begin
        case (rd_kind)
            RD_SGL:  rd_data = words[rd_idx];
            RD_DLO:  rd_data = words[lo_idx];
            RD_DHI:  rd_data = words[hi_idx];
            default: rd_data = sys_rdata;
        endcase
    end

endmodule

// File: rtl/fpreg_xfer_port.sv
module fpreg_xfer_port #(
    parameter int unsigned        NUM_SGL  = 32,
    parameter int unsigned        WORD_W   = 32,
    parameter logic [WORD_W-1:0]  ID_VALUE = 32'h5A01_0C33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [2:0]        xfer_op,
    input  logic [4:0]        xfer_idx,
    input  logic [WORD_W-1:0] xfer_wdata0,
    input  logic [WORD_W-1:0] xfer_wdata1,
    input  logic [1:0]        rd_kind,
    input  logic [4:0]        rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    import fpx_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_SGL);

    logic [NUM_SGL-1:0]             wr_en;
    logic [NUM_SGL-1:0]             lane_hi;
    logic [NUM_SGL-1:0][WORD_W-1:0] sgl_q;
    logic [WORD_W-1:0]              sys_rdata;
    logic                           sys_wr;

    assign sys_wr = xfer_valid && (xfer_op == OP_SYS_WR);

    fpx_wr_decode #(
        .NUM_SGL (NUM_SGL),
        .IDX_W   (IDX_W)
    ) u_dec (
        .xfer_valid (xfer_valid),
        .xfer_op    (xfer_op),
        .xfer_idx   (xfer_idx[IDX_W-1:0]),
        .wr_en      (wr_en),
        .lane_hi    (lane_hi)
    );

    fpx_sgl_bank #(
        .NUM_SGL (NUM_SGL),
        .WORD_W  (WORD_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lane_hi (lane_hi),
        .wdata0  (xfer_wdata0),
        .wdata1  (xfer_wdata1),
        .words   (sgl_q)
    );

    fpx_sys_bank #(
        .WORD_W   (WORD_W),
        .ID_VALUE (ID_VALUE)
    ) u_sys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (sys_wr),
        .wr_sel (xfer_idx[2:0]),
        .wdata  (xfer_wdata0),
        .rd_sel (rd_idx[2:0]),
        .rdata  (sys_rdata)
    );

    fpx_rd_mux #(
        .NUM_SGL (NUM_SGL),
        .WORD_W  (WORD_W),
        .IDX_W   (IDX_W)
    ) u_rd (
        .rd_kind   (rd_kind),
        .rd_idx    (rd_idx[IDX_W-1:0]),
        .words     (sgl_q),
        .sys_rdata (sys_rdata),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
    parameter int unsigned        NUM_SGL  = 32,
    parameter int unsigned        WORD_W   = 32,
    parameter logic [WORD_W-1:0]  ID_VALUE = 32'h5A01_0C33
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            xfer_valid,
    input logic [2:0]                      xfer_op,
    input logic [4:0]                      xfer_idx,
    input logic [WORD_W-1:0]               xfer_wdata0,
    input logic [WORD_W-1:0]               xfer_wdata1,
    input logic [1:0]                      rd_kind,
    input logic [4:0]                      rd_idx,
    input logic [WORD_W-1:0]               rd_data,
    input logic [NUM_SGL-1:0][WORD_W-1:0]  sgl_q
);
    a_r1_single_store: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_op == 3'd0)
        |=> sgl_q[$past(xfer_idx)] == $past(xfer_wdata0));

    a_r2_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_op == 3'd1)
        |=> (sgl_q[{$past(xfer_idx[3:0]), 1'b0}] == $past(xfer_wdata0))
         && (sgl_q[{$past(xfer_idx[3:0]), 1'b1}] == $past(sgl_q[{xfer_idx[3:0], 1'b1}])));

    a_r3_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_op == 3'd2)
        |=> (sgl_q[{$past(xfer_idx[3:0]), 1'b1}] == $past(xfer_wdata0))
         && (sgl_q[{$past(xfer_idx[3:0]), 1'b0}] == $past(sgl_q[{xfer_idx[3:0], 1'b0}])));

    a_r6_pair_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_op == 3'd4 && xfer_idx == 5'd31)
        |=> (sgl_q[0] == $past(xfer_wdata1)) && (sgl_q[31] == $past(xfer_wdata0)));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == 2'd3 && rd_idx[2:0] > 3'd4) |-> rd_data == '0);

    a_r8_id_constant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == 2'd3 && rd_idx[2:0] == 3'd0) |-> rd_data == ID_VALUE);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid || xfer_op == 3'd6 || xfer_op == 3'd7) |=> $stable(sgl_q));

endmodule

bind fpreg_xfer_port fpx_checker #(
    .NUM_SGL  (NUM_SGL),
    .WORD_W   (WORD_W),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_valid  (xfer_valid),
    .xfer_op     (xfer_op),
    .xfer_idx    (xfer_idx),
    .xfer_wdata0 (xfer_wdata0),
    .xfer_wdata1 (xfer_wdata1),
    .rd_kind     (rd_kind),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .sgl_q       (sgl_q)
);

// File: tb/sim_fpreg_xfer_port.sv
module sim_fpreg_xfer_port;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] ID_VAL     = 32'h5A01_0C33;

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  idx;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [1:0]  rk;
        logic [4:0]  ri;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 5'd3,  32'hA1A1_0003, 32'h0, 2'd0, 5'd3,  32'hA1A1_0003, 8'd1},  // R1
        '{3'd1, 5'd2,  32'hB0B0_0000, 32'h0, 2'd0, 5'd4,  32'hB0B0_0000, 8'd2},  // R2 alias S4
        '{3'd2, 5'd2,  32'hB1B1_1111, 32'h0, 2'd1, 5'd2,  32'hB0B0_0000, 8'd3},  // R3 low kept
        '{3'd7, 5'd2,  32'hFFFF_FFFF, 32'h0, 2'd2, 5'd2,  32'hB1B1_1111, 8'd4},  // R4 / R10
        '{3'd3, 5'd5,  32'hC0C0_0000, 32'hC1C1_1111, 2'd0, 5'd11, 32'hC1C1_1111, 8'd5},  // R5
        '{3'd4, 5'd7,  32'hD0D0_0000, 32'hD1D1_1111, 2'd2, 5'd3,  32'hD0D0_0000, 8'd6},  // R6
        '{3'd5, 5'd1,  32'hE1E1_0001, 32'h0, 2'd3, 5'd1,  32'hE1E1_0001, 8'd7},  // R7
        '{3'd5, 5'd0,  32'hDEAD_BEEF, 32'h0, 2'd3, 5'd0,  ID_VAL,        8'd8},  // R8
        '{3'd1, 5'd18, 32'hF0F0_0000, 32'h0, 2'd0, 5'd4,  32'hF0F0_0000, 8'd2},  // R2 bit 4 ignored
        '{3'd5, 5'd6,  32'h0000_0123, 32'h0, 2'd3, 5'd6,  32'h0,         8'd7},  // R7 unmapped
        '{3'd4, 5'd31, 32'h1111_1111, 32'h2222_2222, 2'd0, 5'd0, 32'h2222_2222, 8'd6}  // R6 wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic [2:0]  xfer_op = '0;
    logic [4:0]  xfer_idx = '0;
    logic [31:0] xfer_wdata0 = '0;
    logic [31:0] xfer_wdata1 = '0;
    logic [1:0]  rd_kind = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpreg_xfer_port #(.ID_VALUE(ID_VAL)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_op(xfer_op),
        .xfer_idx(xfer_idx), .xfer_wdata0(xfer_wdata0), .xfer_wdata1(xfer_wdata1),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic peek(input logic [1:0] k, input logic [4:0] i, input string req,
                        input logic [31:0] exp);
        rd_kind = k;
        rd_idx  = i;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] op, input logic [4:0] idx,
                      input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        xfer_valid  = 1'b1;
        xfer_op     = op;
        xfer_idx    = idx;
        xfer_wdata0 = d0;
        xfer_wdata1 = d1;
        @(negedge clk);
        xfer_valid  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset contents
        for (int i = 0; i < 32; i++) peek(2'd0, 5'(i), "R9", 32'h0);
        for (int i = 1; i < 5; i++) peek(2'd3, 5'(i), "R9", 32'h0);
        peek(2'd3, 5'd0, "R9", ID_VAL);
        rst_n = 1'b1;

        // vector table: one write, then one read
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].op, VEC[v].idx, VEC[v].d0, VEC[v].d1);
            peek(VEC[v].rk, VEC[v].ri, $sformatf("R%0d vec%0d", VEC[v].req, v), VEC[v].exp);
        end

        // R6 wrap: first word landed in S31
        peek(2'd0, 5'd31, "R6", 32'h1111_1111);
        // R5 low half of D5
        peek(2'd1, 5'd5, "R5", 32'hC0C0_0000);
        // R6 high half of pair at S8
        peek(2'd0, 5'd8, "R6", 32'hD1D1_1111);
        // R4 high view of D0 after wrap write
        peek(2'd2, 5'd0, "R4", 32'h0);

        // R11: read before the edge shows old data, after shows new
        @(negedge clk);
        xfer_valid = 1'b1; xfer_op = 3'd0; xfer_idx = 5'd9; xfer_wdata0 = 32'h7777_0009;
        peek(2'd0, 5'd9, "R11", 32'h0);
        @(negedge clk);
        xfer_valid = 1'b0;
        peek(2'd0, 5'd9, "R11", 32'h7777_0009);

        // R10: strobe low leaves contents alone
        @(negedge clk);
        xfer_op = 3'd0; xfer_idx = 5'd9; xfer_wdata0 = 32'h9999_9999;
        @(negedge clk);
        peek(2'd0, 5'd9, "R10", 32'h7777_0009);
        // R10: opcode 6 is no effect
        wr(3'd6, 5'd9, 32'h6666_6666, 32'h6666_6666);
        peek(2'd0, 5'd9, "R10", 32'h7777_0009);

        // R7: remaining system registers
        wr(3'd5, 5'd2, 32'h0000_0E02, 32'h0);
        wr(3'd5, 5'd3, 32'h0000_0E03, 32'h0);
        wr(3'd5, 5'd4, 32'h0000_0E04, 32'h0);
        peek(2'd3, 5'd2, "R7", 32'h0000_0E02);
        peek(2'd3, 5'd3, "R7", 32'h0000_0E03);
        peek(2'd3, 5'd4, "R7", 32'h0000_0E04);
        peek(2'd3, 5'd1, "R7", 32'hE1E1_0001);

        // R9: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(2'd0, 5'd0, "R9", 32'h0);
        peek(2'd0, 5'd9, "R9", 32'h0);
        peek(2'd3, 5'd1, "R9", 32'h0);
        peek(2'd3, 5'd0, "R9", ID_VAL);

        finish_run();
    end

endmodule